// File: doc/BRIEF.md
# Serial Byte Receiver with Fill-Level and Idle-Timeout Interrupts

This block receives asynchronous serial characters of ten bit times each: one low start bit, eight data bits sent least significant bit first, and one high stop bit. The receive line passes through a two-flop synchronizer and is oversampled. Each recovered byte goes into a receive queue that the host drains through a first-word-fall-through read port.

Two level interrupts tell the host when to read. The fill interrupt is high while the queue holds at least a programmable number of bytes. This lets the host service the block once per burst rather than once per byte. The idle interrupt covers the bytes left below that level at the end of a message. It asserts when the queue has held a few bytes and neither a push nor a read has happened for four character times.

When the queue is full, the oldest byte is dropped to make room for the newest one, and a sticky overrun flag is raised. A character whose stop bit is sampled low is thrown away, and a sticky framing flag is raised.

Top module: `uart_rx_irq`

## Requirements
- R1: A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts OVS*CLKS_PER_TICK clocks, which is 32 clocks by default. A frame with a high stop bit adds its byte to the queue.
- R2: A low pulse on `rxIn` shorter than half a bit time does not start a frame, and no byte is queued for it.
- R3: A frame whose stop bit is sampled low queues nothing and sets `framingErr`. `framingErr` then stays at 1 until reset.
- R4: `rdData` always shows the oldest queued byte. A `rdStrobe` held for one clock while `fifoEmpty` is 0 removes that byte. A `rdStrobe` while `fifoEmpty` is 1 has no effect.
- R5: `rxIrq` equals `rxIrqEn` AND (`fillLevel` >= effective threshold). The effective threshold is `threshold`, with a value of 0 treated as 1 and any value above FIFO_DEPTH treated as FIFO_DEPTH.
- R6: `toIrq` rises when all of the following hold: 1 <= `fillLevel` < effective threshold, `toIrqEn` is 1, and no push or read has happened for TO_CHARS*10*OVS oversample ticks. By default that is 640 ticks, or 1280 clocks. Once set, `toIrq` stays high until the queue is empty. `toIrqEn` = 0 masks it.
- R7: Every byte pushed and every byte read restarts the idle count from zero. A new full period must then pass before `toIrq` can rise.
- R8: When `fifoEmpty` is 1, both `rxIrq` and `toIrq` are 0.
- R9: A byte that arrives while `fillLevel` = FIFO_DEPTH drops the oldest byte, keeps the newest, and sets `overrunErr`. The next successful read clears `overrunErr`.
- R10: `fillLevel` gives the number of queued bytes (0..FIFO_DEPTH), and `fifoEmpty` is 1 exactly when that number is 0. Reset empties the queue and clears both interrupts and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idles high |
| rdStrobe | input | 1 | Removes the head byte when the queue is not empty |
| threshold | input | CW | Fill level at which `rxIrq` asserts |
| rxIrqEn | input | 1 | Enable for `rxIrq` |
| toIrqEn | input | 1 | Enable for `toIrq` |
| rdData | output | DATA_W | Oldest queued byte |
| fifoEmpty | output | 1 | Queue holds no bytes |
| fillLevel | output | CW | Number of queued bytes |
| rxIrq | output | 1 | Fill-level interrupt |
| toIrq | output | 1 | Idle-timeout interrupt |
| framingErr | output | 1 | Sticky bad-stop-bit flag |
| overrunErr | output | 1 | Sticky overflow flag, cleared by a read |

## Verification
A wrong read or write pointer, or a wrong occupancy count, shows up at once. On the next clock after the bad update, `fillLevel`, `fifoEmpty`, `rdData` or `rxIrq` disagrees with a queue model that is compared on every cycle while the line is quiet. A sampling or framing fault shows up one character later, as a wrong head byte, a missing push or a raised `framingErr`. A fault in the idle timer shows up only around the 1280-clock window, so `toIrq` is probed just before and just after that window.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Strobes from the framing control to the receive datapath
  typedef struct packed {
    logic ovsTick;   // one oversample period has elapsed
    logic shiftEn;   // sample a data bit into the shift register
    logic shiftBit;  // value of the sampled bit
    logic pushByte;  // frame accepted; push the shift register into the queue
    logic frameBad;  // stop bit sampled low
  } rxStrobe_t;

endpackage

// File: rtl/rxFrameCtl.sv
module rxFrameCtl
  import uart_rx_pkg::*;
#(
  parameter int OVS           = 16,
  parameter int CLKS_PER_TICK = 2,
  parameter int DATA_W        = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rxIn,
  output rxStrobe_t strb
);

  localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int SC_W  = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int BI_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_e;

  logic [PRE_W-1:0] preCnt;
  logic             ovsTick;
  logic [1:0]       syncQ;
  logic             rxS;
  rxState_e         state;
  logic [SC_W-1:0]  sc;
  logic [BI_W-1:0]  bitIdx;
  logic             atBitEnd;

  // Oversample tick prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   preCnt <= '0;
    else if (preCnt == PRE_W'(CLKS_PER_TICK - 1)) preCnt <= '0;
    else                                          preCnt <= preCnt + 1'b1;
  end
  assign ovsTick = (preCnt == PRE_W'(CLKS_PER_TICK - 1));

  // Two-flop synchronizer, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b11;
    else        syncQ <= {syncQ[0], rxIn};
  end
  assign rxS = syncQ[1];

  assign atBitEnd = ovsTick && (sc == SC_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sc     <= '0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (ovsTick && !rxS) begin
          state <= ST_START;
          sc    <= '0;
        end
        ST_START: if (ovsTick) begin
          if (sc == SC_W'(HALF - 1)) begin
            sc <= '0;
            if (!rxS) begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            sc <= sc + 1'b1;
          end
        end
        ST_DATA: if (atBitEnd) begin
          sc <= '0;
          if (bitIdx == BI_W'(DATA_W - 1)) state <= ST_STOP;
          else                             bitIdx <= bitIdx + 1'b1;
        end else if (ovsTick) begin
          sc <= sc + 1'b1;
        end
        ST_STOP: if (atBitEnd) begin
          sc    <= '0;
          state <= ST_IDLE;
        end else if (ovsTick) begin
          sc <= sc + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.ovsTick  = ovsTick;
    strb.shiftBit = rxS;
    strb.shiftEn  = atBitEnd && (state == ST_DATA);
    strb.pushByte = atBitEnd && (state == ST_STOP) && rxS;
    strb.frameBad = atBitEnd && (state == ST_STOP) && !rxS;
  end

endmodule

// File: rtl/rxFifoPath.sv
module rxFifoPath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  parameter int TO_TICKS = 640,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxStrobe_t         strb,
  input  logic              rdStrobe,
  input  logic [CW-1:0]     threshold,
  input  logic              rxIrqEn,
  input  logic              toIrqEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic [CW-1:0]     fillLevel,
  output logic              rxIrq,
  output logic              toIrq,
  output logic              framingErr,
  output logic              overrunErr
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = $clog2(TO_TICKS + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count, thrEff;
  logic [TW-1:0]     toCnt;
  logic              rdValid, isFull, dropOld, toExpired, toFlag;

  function automatic logic [AW-1:0] ptrNext(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign isFull  = (count == CW'(DEPTH));
  assign rdValid = rdStrobe && (count != '0);
  assign dropOld = strb.pushByte && isFull && !rdValid;

  // Serial-to-parallel, least significant bit first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.shiftBit, shiftReg[DATA_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (strb.pushByte) mem[wrPtr] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.pushByte)      wrPtr <= ptrNext(wrPtr);
      if (rdValid || dropOld) rdPtr <= ptrNext(rdPtr);
      if (strb.pushByte && !rdValid && !isFull) count <= count + 1'b1;
      else if (rdValid && !strb.pushByte)       count <= count - 1'b1;
    end
  end

  // Clamp the threshold into 1..DEPTH
  always_comb begin
    if (threshold == '0)                 thrEff = CW'(1);
    else if (threshold > CW'(DEPTH))     thrEff = CW'(DEPTH);
    else                                 thrEff = threshold;
  end

  // Idle timer in oversample ticks
  assign toExpired = (toCnt == TW'(TO_TICKS));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        toCnt <= '0;
    else if (count == '0 || strb.pushByte || rdValid)  toCnt <= '0;
    else if (strb.ovsTick && !toExpired)               toCnt <= toCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              toFlag <= 1'b0;
    else if (count == '0)                    toFlag <= 1'b0;
    else if (toExpired && (count < thrEff))  toFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      framingErr <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (strb.frameBad) framingErr <= 1'b1;
      if (dropOld)       overrunErr <= 1'b1;
      else if (rdValid)  overrunErr <= 1'b0;
    end
  end

  assign rdData    = mem[rdPtr];
  assign fifoEmpty = (count == '0);
  assign fillLevel = count;
  assign rxIrq     = rxIrqEn && (count != '0) && (count >= thrEff);
  assign toIrq     = toIrqEn && toFlag && (count != '0);

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int OVS           = 16,
  parameter int CLKS_PER_TICK = 2,
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int TO_CHARS      = 4,
  parameter int CW            = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxIn,
  input  logic              rdStrobe,
  input  logic [CW-1:0]     threshold,
  input  logic              rxIrqEn,
  input  logic              toIrqEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoEmpty,
  output logic [CW-1:0]     fillLevel,
  output logic              rxIrq,
  output logic              toIrq,
  output logic              framingErr,
  output logic              overrunErr
);

  localparam int CHAR_BITS = DATA_W + 2;
  localparam int TO_TICKS  = TO_CHARS * CHAR_BITS * OVS;

  rxStrobe_t ctlStrb;

  rxFrameCtl #(.OVS(OVS), .CLKS_PER_TICK(CLKS_PER_TICK), .DATA_W(DATA_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .rxIn(rxIn), .strb(ctlStrb)
  );

  rxFifoPath #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .TO_TICKS(TO_TICKS), .CW(CW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(ctlStrb), .rdStrobe(rdStrobe),
    .threshold(threshold), .rxIrqEn(rxIrqEn), .toIrqEn(toIrqEn),
    .rdData(rdData), .fifoEmpty(fifoEmpty), .fillLevel(fillLevel),
    .rxIrq(rxIrq), .toIrq(toIrq), .framingErr(framingErr), .overrunErr(overrunErr)
  );

endmodule

// File: rtl/uart_rx_irq_chk.sv
module uart_rx_irq_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdStrobe,
  input logic          pushByte,
  input logic [CW-1:0] threshold,
  input logic          rxIrqEn,
  input logic          toIrqEn,
  input logic          fifoEmpty,
  input logic [CW-1:0] fillLevel,
  input logic          rxIrq,
  input logic          toIrq,
  input logic          framingErr,
  input logic          overrunErr
);

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillLevel <= CW'(DEPTH));

  // R5
  rx_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> (rxIrqEn && (fillLevel >= threshold || fillLevel == CW'(DEPTH))));

  // R8
  irq_quiet_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoEmpty |-> (!rxIrq && !toIrq));

  // R6
  to_irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toIrq |-> toIrqEn);

  // R4
  read_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !fifoEmpty && !pushByte) |=> (fillLevel == $past(fillLevel) - 1'b1));

  // R9
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushByte && fillLevel == CW'(DEPTH) && !rdStrobe) |=> (overrunErr && fillLevel == CW'(DEPTH)));

  // R3
  framing_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    framingErr |=> framingErr);

endmodule

bind uart_rx_irq uart_rx_irq_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rdStrobe(rdStrobe), .pushByte(ctlStrb.pushByte),
  .threshold(threshold), .rxIrqEn(rxIrqEn), .toIrqEn(toIrqEn),
  .fifoEmpty(fifoEmpty), .fillLevel(fillLevel), .rxIrq(rxIrq), .toIrq(toIrq),
  .framingErr(framingErr), .overrunErr(overrunErr)
);

// File: tb/uart_rx_irq_tb_top.sv
module uart_rx_irq_tb_top;

  localparam int DEPTH    = 8;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int BIT_CLKS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxIn = 1'b1;
  logic          rdStrobe = 1'b0;
  logic [CW-1:0] threshold = CW'(1);
  logic          rxIrqEn = 1'b1;
  logic          toIrqEn = 1'b1;
  logic [7:0]    rdData;
  logic          fifoEmpty, rxIrq, toIrq, framingErr, overrunErr;
  logic [CW-1:0] fillLevel;

  int  nVec = 0;
  int  nBad = 0;
  bit  modelValid = 0;
  bit  done = 0;
  byte unsigned q[$];
  bit  mOvr = 0;
  bit  mFrm = 0;

  always #5 clk = ~clk;

  uart_rx_irq dut_i (
    .clk(clk), .rst_n(rst_n), .rxIn(rxIn), .rdStrobe(rdStrobe),
    .threshold(threshold), .rxIrqEn(rxIrqEn), .toIrqEn(toIrqEn),
    .rdData(rdData), .fifoEmpty(fifoEmpty), .fillLevel(fillLevel),
    .rxIrq(rxIrq), .toIrq(toIrq), .framingErr(framingErr), .overrunErr(overrunErr)
  );

  function automatic int effThr(int t);
    if (t < 1) return 1;
    if (t > DEPTH) return DEPTH;
    return t;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the queue model while the line is quiet
  always @(posedge clk) begin
    #3;
    if (modelValid && rst_n && !done) begin
      chk("R10", "fillLevel", int'(fillLevel), q.size());
      chk("R10", "fifoEmpty", int'(fifoEmpty), int'(q.size() == 0));
      chk("R5", "rxIrq", int'(rxIrq), int'(rxIrqEn && q.size() >= effThr(int'(threshold))));
      chk("R9", "overrunErr", int'(overrunErr), int'(mOvr));
      chk("R3", "framingErr", int'(framingErr), int'(mFrm));
      if (q.size() > 0) chk("R4", "rdData", int'(rdData), int'(q[0]));
      if (q.size() == 0) chk("R8", "toIrq when empty", int'(toIrq), 0);
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(byte unsigned b, bit stopOk);
    modelValid = 0;
    rxIn = 1'b0;
    waitClk(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      waitClk(BIT_CLKS);
    end
    rxIn = stopOk;
    waitClk(BIT_CLKS);
    rxIn = 1'b1;
    if (stopOk) begin
      if (q.size() == DEPTH) begin
        void'(q.pop_front());
        mOvr = 1;
      end
      q.push_back(b);
    end else begin
      mFrm = 1;
    end
    waitClk(4);
    modelValid = 1;
  endtask

  task automatic readOne();
    @(negedge clk);
    rdStrobe = 1'b1;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      void'(q.pop_front());
      mOvr = 0;
    end
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) readOne();
    waitClk(2);
  endtask

  initial begin
    waitClk(150000);
    if (!done) begin
      nBad++;
      nVec++;
      $display("FAIL watchdog: actual hung expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    waitClk(5);
    rst_n = 1'b1;
    waitClk(2);
    // R10 reset state
    chk("R10", "reset fifoEmpty", int'(fifoEmpty), 1);
    chk("R10", "reset fillLevel", int'(fillLevel), 0);
    chk("R8", "reset irqs", int'(rxIrq | toIrq), 0);
    chk("R10", "reset flags", int'(framingErr | overrunErr), 0);
    modelValid = 1;

    // R4 read on empty is ignored
    readOne();
    chk("R4", "empty read level", int'(fillLevel), 0);

    // R1 R5 decode and threshold
    threshold = CW'(2);
    sendByte(8'hA5, 1'b1);
    chk("R1", "first byte", int'(rdData), 8'hA5);
    chk("R5", "below threshold", int'(rxIrq), 0);
    sendByte(8'h3C, 1'b1);
    chk("R5", "at threshold", int'(rxIrq), 1);
    rxIrqEn = 1'b0;
    waitClk(1);
    chk("R5", "masked rxIrq", int'(rxIrq), 0);
    rxIrqEn = 1'b1;
    readOne();
    chk("R4", "second byte head", int'(rdData), 8'h3C);
    drain();
    chk("R8", "rxIrq after drain", int'(rxIrq), 0);

    // R6 timeout with a single stranded byte
    threshold = CW'(4);
    sendByte(8'h81, 1'b1);
    waitClk(1150);
    chk("R6", "toIrq before window", int'(toIrq), 0);
    waitClk(200);
    chk("R6", "toIrq after window", int'(toIrq), 1);
    toIrqEn = 1'b0;
    waitClk(1);
    chk("R6", "toIrq masked", int'(toIrq), 0);
    toIrqEn = 1'b1;
    drain();
    chk("R8", "toIrq cleared on empty", int'(toIrq), 0);

    // R7 a read restarts the idle count
    sendByte(8'h11, 1'b1);
    sendByte(8'h22, 1'b1);
    waitClk(1000);
    readOne();
    waitClk(1000);
    chk("R7", "toIrq after read restart", int'(toIrq), 0);
    waitClk(400);
    chk("R7", "toIrq after new window", int'(toIrq), 1);
    drain();

    // R6 no timeout when the level meets the threshold
    threshold = CW'(1);
    sendByte(8'h5A, 1'b1);
    waitClk(1500);
    chk("R6", "no toIrq at threshold", int'(toIrq), 0);
    drain();

    // R5 clamping of threshold 0
    threshold = CW'(0);
    sendByte(8'h77, 1'b1);
    chk("R5", "threshold 0 acts as 1", int'(rxIrq), 1);
    drain();

    // R2 short glitch is not a start bit
    rxIn = 1'b0;
    waitClk(4);
    rxIn = 1'b1;
    waitClk(BIT_CLKS * 12);
    chk("R2", "glitch level", int'(fillLevel), 0);

    // R9 overflow drops oldest
    threshold = CW'(8);
    for (int i = 0; i < 10; i++) sendByte(byte'(8'h10 + i), 1'b1);
    chk("R9", "full level", int'(fillLevel), DEPTH);
    chk("R9", "overrun set", int'(overrunErr), 1);
    chk("R9", "head after drop", int'(rdData), 8'h12);
    readOne();
    chk("R9", "overrun cleared by read", int'(overrunErr), 0);
    drain();

    // R3 bad stop bit
    threshold = CW'(1);
    sendByte(8'h55, 1'b0);
    waitClk(BIT_CLKS);
    chk("R3", "bad frame not queued", int'(fillLevel), 0);
    chk("R3", "framing set", int'(framingErr), 1);
    sendByte(8'hC3, 1'b1);
    chk("R1", "good byte after bad frame", int'(rdData), 8'hC3);
    chk("R3", "framing sticky", int'(framingErr), 1);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule